// File: doc/BRIEF.md
# Dual 32K Window Bank Mapper

This block sits between an 8-bit processor with a 16-bit address bus and a larger physical memory. It splits the 64K processor space into a lower and an upper 32K window. Each window has its own bank field, which names one 32K block of physical memory. Address line A15 picks which field is used. That field then takes the place of A15 on the way to memory, so the physical address is `{bank_addr, cpu_addr[14:0]}`.

Software loads the bank fields through I/O writes. A parameter selects between two layouts:

- **Packed mode (`DUAL_PORT = 0`):** one 8-bit port holds two 4-bit fields, which gives 16 blocks, or 512K.
- **Split mode (`DUAL_PORT = 1`):** each window has its own 8-bit port. This gives 8-bit fields, but changing both windows takes one extra write.

Both fields can be read back through the same ports. The mapping output is combinational from A15 and adds no clock latency to the memory path.

Top module: `cpu_bank32_map`

## Requirements
- R1: After reset, the lower field is 0 and the upper field is 1. As a result, A15=0 gives `bank_addr` 0x00, A15=1 gives 0x01, and the mapping is flat.
- R2: `bank_addr` follows `cpu_a15` in the same cycle. A15=0 outputs the lower field and A15=1 outputs the upper field.
- R3: In packed mode, a write to `PORT_LO` loads `wdata[3:0]` into the lower field and `wdata[7:4]` into the upper field in one write. `bank_addr[7:4]` is always 0 in this mode.
- R4: In split mode, a write to `PORT_LO` loads all 8 bits of `wdata` into the lower field, and a write to `PORT_HI` loads all 8 bits into the upper field. Each write leaves the other field unchanged.
- R5: A write to any address that is not a port of the active mode changes neither field. In packed mode, `PORT_HI` is not a port.
- R6: With `io_rd` high on a port of the active mode, `rd_hit` is 1.
  - In packed mode, `rdata` is `{upper, lower}`.
  - In split mode, `PORT_LO` returns the lower field and `PORT_HI` returns the upper field.
  - Any other read gives `rd_hit` 0 and `rdata` 0x00.
- R7: A field changes only on the clock edge at which its port is written. With `io_wr` low, both fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| wdata | input | 8 | I/O write data |
| cpu_a15 | input | 1 | Processor address bit 15 (window select) |
| bank_addr | output | 8 | Physical block number that replaces A15 |
| rdata | output | 8 | Read-back data, 0 when not hit |
| rd_hit | output | 1 | Read addressed a bank port |

## Verification
The bench runs a packed instance and a split instance side by side on the same stimulus.

After every vector, it checks both windows and reads back both ports. Driving A15 both ways shows whether the two fields are swapped or merged. Reading back shows whether the nibble split and the per-port routing are correct.

Directed writes cover the following cases:
- The packed high port, which must be ignored.
- A foreign address.
- A port address with the strobe low.

These separate real decoding from loose matching. A long run of random writes, mixed across the two ports and random addresses, then shows that one window's field never leaks into the other's.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int unsigned BYTE_W = 8;

  // width of one bank field for the selected port layout
  function automatic int unsigned field_w(input bit dual);
    return dual ? 32'd8 : 32'd4;
  endfunction
endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/bank_field_reg.sv
module bank_field_reg #(
  parameter int unsigned W       = 4,
  parameter logic [7:0]  RST_VAL = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL[W-1:0];
    else        q <= q_nxt;
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)) else $error("field changed without write"); // R7

  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(d))) else $error("field did not take write data"); // R3
endmodule

// File: rtl/bank_sel.sv
module bank_sel #(
  parameter int unsigned W = 4
) (
  input  logic         a15,
  input  logic [W-1:0] lo_field,
  input  logic [W-1:0] hi_field,
  output logic [W-1:0] blk
);
  always_comb begin
    blk = lo_field;
    if (a15) blk = hi_field;
  end
endmodule

// File: rtl/cpu_bank32_map.sv
module cpu_bank32_map #(
  parameter bit         DUAL_PORT = 1'b0,
  parameter logic [7:0] PORT_LO   = 8'h40,
  parameter logic [7:0] PORT_HI   = 8'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [7:0] wdata,
  input  logic       cpu_a15,
  output logic [7:0] bank_addr,
  output logic [7:0] rdata,
  output logic       rd_hit
);
  import bank_map_pkg::*;

  localparam int unsigned FW = field_w(DUAL_PORT);

  logic          rst_sync_n;
  logic          hit_lo, hit_hi;
  logic          wr_lo, wr_hi;
  logic [FW-1:0] lo_d, hi_d, lo_q, hi_q, blk;
  logic [7:0]    rd_val;

  bank_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign hit_lo = (io_addr == PORT_LO);
  assign wr_lo  = io_wr && hit_lo;

  generate
    if (DUAL_PORT) begin : g_split
      assign hit_hi = (io_addr == PORT_HI);
      assign wr_hi  = io_wr && hit_hi;
      assign lo_d   = wdata;
      assign hi_d   = wdata;
      assign rd_val = hit_hi ? 8'(hi_q) : 8'(lo_q);
    end else begin : g_packed
      assign hit_hi = 1'b0;
      assign wr_hi  = wr_lo;
      assign lo_d   = wdata[FW-1:0];
      assign hi_d   = wdata[2*FW-1:FW];
      assign rd_val = {hi_q, lo_q};
    end
  endgenerate

  bank_field_reg #(.W(FW), .RST_VAL(8'h00)) i_lo_field (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_lo),
    .d     (lo_d),
    .q     (lo_q)
  );

  bank_field_reg #(.W(FW), .RST_VAL(8'h01)) i_hi_field (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_hi),
    .d     (hi_d),
    .q     (hi_q)
  );

  bank_sel #(.W(FW)) i_sel (
    .a15      (cpu_a15),
    .lo_field (lo_q),
    .hi_field (hi_q),
    .blk      (blk)
  );

  assign bank_addr = 8'(blk);
  assign rd_hit    = io_rd && (hit_lo || hit_hi);
  assign rdata     = rd_hit ? rd_val : 8'h00;

  AST_FOREIGN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && !hit_lo && !(DUAL_PORT && (io_addr == PORT_HI)))
      |=> ($stable(lo_q) && $stable(hi_q))) else $error("foreign write altered a field"); // R5

  AST_UPPER_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_a15 |-> (bank_addr == 8'(hi_q))) else $error("upper window mapped wrong"); // R2

  AST_LOWER_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cpu_a15 |-> (bank_addr == 8'(lo_q))) else $error("lower window mapped wrong"); // R2
endmodule

// File: tb/test_cpu_bank32_map.sv
module test_cpu_bank32_map;
  localparam logic [7:0] P_LO = 8'h40;
  localparam logic [7:0] P_HI = 8'h41;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] io_addr;
  logic       io_wr, io_rd, cpu_a15;
  logic [7:0] wdata;
  logic [7:0] s_bank, s_rdata, d_bank, d_rdata;
  logic       s_hit, d_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench models
  logic [3:0] s_lo, s_hi;
  logic [7:0] d_lo, d_hi;

  always #5 clk = ~clk;

  cpu_bank32_map #(.DUAL_PORT(1'b0), .PORT_LO(P_LO), .PORT_HI(P_HI)) i_cpu_bank32_map (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .wdata(wdata), .cpu_a15(cpu_a15), .bank_addr(s_bank), .rdata(s_rdata), .rd_hit(s_hit)
  );

  cpu_bank32_map #(.DUAL_PORT(1'b1), .PORT_LO(P_LO), .PORT_HI(P_HI)) i_cpu_bank32_map_dual (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .wdata(wdata), .cpu_a15(cpu_a15), .bank_addr(d_bank), .rdata(d_rdata), .rd_hit(d_hit)
  );

  function automatic logic [8:0] exp_rd_packed(input logic [7:0] a, input logic [3:0] lo,
                                               input logic [3:0] hi);
    return (a == P_LO) ? {1'b1, hi, lo} : 9'h000;
  endfunction

  function automatic logic [8:0] exp_rd_split(input logic [7:0] a, input logic [7:0] lo,
                                              input logic [7:0] hi);
    if (a == P_LO) return {1'b1, lo};
    if (a == P_HI) return {1'b1, hi};
    return 9'h000;
  endfunction

  task automatic chk(input string req, input string what, input logic [8:0] act,
                     input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one bus cycle; the write lands at the posedge in between
  task automatic bus_cycle(input logic [7:0] a, input logic [7:0] d, input logic wr);
    @(negedge clk);
    io_addr = a; wdata = d; io_wr = wr; io_rd = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
    if (wr && a == P_LO) begin s_lo = d[3:0]; s_hi = d[7:4]; end
    if (wr && a == P_LO) d_lo = d;
    if (wr && a == P_HI) d_hi = d;
  endtask

  // checks both windows and reads back both ports, between edges
  task automatic check_all(input string rw, input string rr);
    cpu_a15 = 1'b0; #1;
    chk(rw, "packed lower window", {1'b0, s_bank}, {5'h00, s_lo});
    chk(rw, "split lower window",  {1'b0, d_bank}, {1'b0, d_lo});
    cpu_a15 = 1'b1; #1;
    chk(rw, "packed upper window", {1'b0, s_bank}, {5'h00, s_hi});
    chk(rw, "split upper window",  {1'b0, d_bank}, {1'b0, d_hi});
    io_rd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      io_addr = (k == 0) ? P_LO : (k == 1) ? P_HI : 8'h7F; #0.5;
      chk(rr, "packed readback", {s_hit, s_rdata}, exp_rd_packed(io_addr, s_lo, s_hi));
      chk(rr, "split readback",  {d_hit, d_rdata}, exp_rd_split(io_addr, d_lo, d_hi));
    end
    io_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; io_addr = 8'h00; io_wr = 1'b0; io_rd = 1'b0; wdata = 8'h00; cpu_a15 = 1'b0;
    s_lo = 4'h0; s_hi = 4'h1; d_lo = 8'h00; d_hi = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1", "R1");

    // R3 packed nibble split; split mode takes whole byte into lower only (R4)
    bus_cycle(P_LO, 8'hA5, 1'b1);
    check_all("R3", "R6");
    // R4 upper port; packed mode ignores it (R5)
    bus_cycle(P_HI, 8'hF0, 1'b1);
    check_all("R4", "R6");
    // R5 foreign address
    bus_cycle(8'h7F, 8'h3C, 1'b1);
    check_all("R5", "R6");
    // R7 port address with strobe low
    bus_cycle(P_LO, 8'h99, 1'b0);
    check_all("R7", "R6");
    bus_cycle(P_HI, 8'h11, 1'b0);
    check_all("R7", "R6");
    // R2 extremes
    bus_cycle(P_LO, 8'h0F, 1'b1);
    bus_cycle(P_HI, 8'hFF, 1'b1);
    check_all("R2", "R6");

    for (int i = 0; i < 400; i++) begin
      int unsigned sel = $urandom % 4;
      logic [7:0] a = (sel == 0) ? P_LO : (sel == 1) ? P_HI : 8'($urandom);
      logic       w = (sel == 3) ? 1'b0 : 1'($urandom % 8 != 0);
      bus_cycle(a, 8'($urandom), w);
      check_all("R2", "R6");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule